// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block holds the digital side of an 8-bit successive-approximation converter together with a two-register CPU interface. A control register carries a channel number, a run bit and a done flag. A result register returns the latest code. The CPU clock is divided by four to give the converter clock. While the run bit is set and the chip is not halted, the sequencer repeats one fixed pattern without pause. It first loads the sample for 4 converter clocks. It then makes 8 binary-search steps, presenting a trial code to the external DAC and reading a one-bit comparator answer at the end of each step.

Software sets the channel and the run bit in a single write. It then polls the done flag and reads the result register, which holds each code until the next conversion finishes. Another write with the run bit set throws away the conversion in flight and starts again from sampling. No interrupt is produced. The mux, the sample capacitor, the DAC and the comparator sit outside the block. The block reaches them through the channel, sample-enable and trial-code outputs and the compare input.

Top module: `adc_seq_top`

## Requirements
- R1: Each converter clock period lasts exactly 4 CPU clock cycles. The counting starts from the enabling write or from the release of halt.
- R2: A conversion lasts 12 converter clocks, that is 48 CPU cycles. After a write at clock edge E0 with the run bit (bit 5) set, the done flag (control bit 7) reads 0 after edge E47 and 1 after edge E48.
- R3: sample_en_o is high during the first 4 converter clocks of every conversion, which is the 16 cycles after edges E0 to E15. It is low during the 8 approximation clocks.
- R4: The search starts at trial code 80h and works from the most significant bit down. A bit is kept when cmp_i is high, which means the input is at or above the trial level. With an ideal comparator the result equals the input code, so it is FFh at full scale and 00h at the bottom reference.
- R5: At the end of each conversion the done flag is set and the result register (address 1) is loaded with the new code.
- R6: While running, conversions follow one another every 48 cycles with no pause. The result register keeps its value until the next conversion completes.
- R7: A control write (address 0) with bit 5 set aborts the current conversion, clears the done flag and restarts from the sampling phase.
- R8: A control write with bit 5 clear stops the sequencer from the next cycle. sample_en_o and trial_code_o read 0, the result register keeps its value and no further conversion completes.
- R9: While halt_i is high the converter is idle, with sample_en_o and trial_code_o at 0. After release, a full conversion completes 48 edges after the last edge at which halt_i was high.
- R10: chan_sel_o follows control bits 3:0. The control register reads {done, 0, run, 0, channel}. Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Chip halt; forces the converter idle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 result |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| chan_sel_o | output | 4 | Analog channel select |
| sample_en_o | output | 1 | Connects the input to the sample capacitor |
| trial_code_o | output | 8 | Trial code for the DAC during approximation |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |

## Verification
Each result is counted in clock edges from the edge that captures the enabling write, E0. Sample-enable drops after E16, the first trial code 80h appears after E16, and the done flag and new result arrive after E48, then every 48 edges while running. After a halt release the same count starts from the last halted edge. The bench samples on falling edges and checks one edge early and then on time, so a conversion that ends early or late is caught. An ideal comparator is modelled arithmetically from the trial code, so the expected result of each sweep point is the input code itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CTRL_RUN_BIT  = 5;
    localparam int CTRL_DONE_BIT = 7;
    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_RESULT = 1'b1;

    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_SEARCH = 1'b1
    } phase_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.cnt == CNT_W'(DIV - 1));
        if (clr_i || !run_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SAMPLE_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              cmp_i,
    output logic              sample_en_o,
    output logic [DATA_W-1:0] trial_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int SLOTS  = SAMPLE_SLOTS + DATA_W;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] sar;
    } core_st_t;

    core_st_t          st_q, st_d;
    phase_e            phase;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] trial;
    logic [SLOT_W-1:0] shift;

    always_comb begin
        phase    = (st_q.slot >= SLOT_W'(SAMPLE_SLOTS)) ? PH_SEARCH : PH_SAMPLE;
        shift    = SLOT_W'(SLOTS - 1) - st_q.slot;
        bit_mask = (phase == PH_SEARCH) ? (DATA_W'(1) << shift) : '0;
        trial    = st_q.sar | bit_mask;
        result_o = cmp_i ? trial : st_q.sar;

        st_d   = st_q;
        done_o = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (st_q.slot == SLOT_W'(SLOTS - 1)) begin
                st_d.slot = '0;
                st_d.sar  = '0;
                done_o    = 1'b1;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
                if (phase == PH_SEARCH) st_d.sar = result_o;
            end
        end

        sample_en_o = run_i && (phase == PH_SAMPLE);
        trial_o     = (run_i && phase == PH_SEARCH) ? trial : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot < SLOT_W'(SLOTS)); // R2
    AST_SAMPLE_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> (trial_o == '0)); // R3
    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i && $past(sample_en_o) && !sample_en_o && $past(run_i))
        |-> (trial_o == (DATA_W'(1) << (DATA_W - 1)))); // R4
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CH_W         = 4,
    parameter int DIV          = 4,
    parameter int SAMPLE_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic              sample_en_o,
    output logic [DATA_W-1:0] trial_code_o,
    input  logic              cmp_i
);
    typedef struct packed {
        logic              run;
        logic [CH_W-1:0]   chan;
        logic              done;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t             rg_q, rg_d;
    logic              ctrl_wr;
    logic              restart;
    logic              active;
    logic              clr;
    logic              tick;
    logic              conv_done;
    logic [DATA_W-1:0] conv_result;

    always_comb begin
        ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
        restart = ctrl_wr && reg_wdata_i[CTRL_RUN_BIT];
        active  = rg_q.run && !halt_i;
        clr     = restart || !active;

        rg_d = rg_q;
        if (ctrl_wr) begin
            rg_d.run  = reg_wdata_i[CTRL_RUN_BIT];
            rg_d.chan = reg_wdata_i[CH_W-1:0];
        end
        if (restart) begin
            rg_d.done = 1'b0;
        end else if (conv_done) begin
            rg_d.done = 1'b1;
            rg_d.data = conv_result;
        end

        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_CTRL) begin
            reg_rdata_o[CH_W-1:0]     = rg_q.chan;
            reg_rdata_o[CTRL_RUN_BIT]  = rg_q.run;
            reg_rdata_o[CTRL_DONE_BIT] = rg_q.done;
        end else begin
            reg_rdata_o[DATA_W-1:0] = rg_q.data;
        end
        chan_sel_o = rg_q.chan;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    adc_clk_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .run_i  (active),
        .tick_o (tick)
    );

    adc_sar_core #(.DATA_W(DATA_W), .SAMPLE_SLOTS(SAMPLE_SLOTS)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .run_i       (active),
        .tick_i      (tick),
        .cmp_i       (cmp_i),
        .sample_en_o (sample_en_o),
        .trial_o     (trial_code_o),
        .done_o      (conv_done),
        .result_o    (conv_result)
    );

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !restart) |=> rg_q.done); // R5
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(rg_q.data)); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !rg_q.done); // R7
    AST_OFF_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.run |-> !conv_done); // R8
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> (!sample_en_o && trial_code_o == '0 && !conv_done)); // R9
endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [3:0] chan_sel_o;
    logic       sample_en_o;
    logic [7:0] trial_code_o;
    logic       cmp_i;
    logic [7:0] vin = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;
    logic [7:0] held;

    always #4 clk = ~clk;

    assign cmp_i = (vin >= trial_code_o);

    adc_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .chan_sel_o(chan_sel_o), .sample_en_o(sample_en_o), .trial_code_o(trial_code_o),
        .cmp_i(cmp_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_addr_i = 1'b0;
    endtask

    task automatic rdreg(input logic a, output logic [7:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
        reg_addr_i = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        rdreg(1'b0, rd); chk("R10 reset ctrl", rd, 8'h00);
        rdreg(1'b1, rd); chk("R10 reset data", rd, 8'h00);
        chk("R8 reset sample_en", sample_en_o, 0);
        chk("R8 reset trial", trial_code_o, 0);

        // R10: channel field, run clear, no conversion
        wr(1'b0, 8'h0A);
        chk("R10 chan_sel", chan_sel_o, 4'hA);
        rdreg(1'b0, rd); chk("R10 ctrl readback", rd, 8'h0A);
        edges(60);
        rdreg(1'b0, rd); chk("R8 idle no done", rd, 8'h0A);
        chk("R8 idle sample_en", sample_en_o, 0);

        // R1 R2 R3 R4: timing of one conversion
        vin = 8'hC3;
        wr(1'b0, 8'h23);
        chk("R10 chan after enable", chan_sel_o, 4'h3);
        chk("R3 sample after E0", sample_en_o, 1);
        edges(15);
        chk("R3 sample after E15", sample_en_o, 1);
        chk("R1 no trial during sample", trial_code_o, 0);
        edges(1);
        chk("R3 sample low after E16", sample_en_o, 0);
        chk("R4 first trial 80h", trial_code_o, 8'h80);
        edges(3);
        chk("R1 trial holds 4 cycles", trial_code_o, 8'h80);
        edges(1);
        chk("R4 second trial", trial_code_o, 8'hC0);
        edges(27);
        rdreg(1'b0, rd); chk("R2 not done after E47", rd[7], 0);
        edges(1);
        rdreg(1'b0, rd); chk("R2 done after E48", rd, 8'hA3);
        rdreg(1'b1, rd); chk("R5 result", rd, 8'hC3);
        chk("R6 next sampling starts", sample_en_o, 1);

        // R6: back-to-back conversion, hold then update
        vin = 8'h5A;
        edges(47);
        rdreg(1'b1, rd); chk("R6 result held after E95", rd, 8'hC3);
        edges(1);
        rdreg(1'b1, rd); chk("R6 result updated after E96", rd, 8'h5A);

        // R10: write to result address ignored
        wr(1'b1, 8'h11);
        rdreg(1'b1, rd); chk("R10 data write ignored", rd, 8'h5A);

        // R7: abort mid conversion
        edges(20);
        vin = 8'h3C;
        wr(1'b0, 8'h25);
        rdreg(1'b0, rd); chk("R7 flag cleared", rd, 8'h25);
        chk("R7 restart sampling", sample_en_o, 1);
        edges(47);
        rdreg(1'b0, rd); chk("R7 not done at E47", rd[7], 0);
        edges(1);
        rdreg(1'b1, rd); chk("R7 result after restart", rd, 8'h3C);

        // R8: stop
        edges(10);
        wr(1'b0, 8'h05);
        chk("R8 sample_en off", sample_en_o, 0);
        chk("R8 trial off", trial_code_o, 0);
        vin = 8'hFF;
        edges(120);
        rdreg(1'b1, rd); chk("R8 result kept", rd, 8'h3C);
        rdreg(1'b0, rd); chk("R8 flag kept", rd, 8'h85);

        // R9: halt
        vin = 8'h99;
        wr(1'b0, 8'h21);
        edges(25);
        halt_i = 1'b1;
        #1;
        chk("R9 halt sample_en", sample_en_o, 0);
        chk("R9 halt trial", trial_code_o, 0);
        edges(80);
        rdreg(1'b0, rd); chk("R9 no done in halt", rd[7], 0);
        halt_i = 1'b0;
        #1;
        chk("R9 sampling after release", sample_en_o, 1);
        edges(47);
        rdreg(1'b0, rd); chk("R9 not done early", rd[7], 0);
        edges(1);
        rdreg(1'b0, rd); chk("R9 done after release", rd[7], 1);
        rdreg(1'b1, rd); chk("R9 result", rd, 8'h99);

        // R4: exhaustive sweep of input codes
        for (int v = 0; v < 256; v++) begin
            vin = 8'(v);
            wr(1'b0, 8'h20 | 8'(v & 15));
            edges(48);
            rdreg(1'b1, rd);
            chk("R4 sweep result", rd, v);
        end
        held = rd;
        chk("R4 full scale FF", held, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule